// File: doc/BRIEF.md
# Sustained Change Notification Filter

This block watches an 8-bit guaranteed-performance level that an external limit agent drives. It passes on only those changes that last. When the raw level moves away from the published level, the new value becomes a candidate. The candidate is qualified against a periodic one-cycle tick. It is published only after it has stayed unchanged for more than a programmable number of ticks. The default count stands for one second of a 1 kHz tick.

Each accepted change does three things:
- it updates the published level;
- it sets a sticky status flag that software clears with a write;
- it raises the interrupt line, but only while interrupts are enabled.

Short excursions and fast flicker produce no notification. Because of this, notifications come at most about once per qualification window.

Top module: `perf_change_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pub_lvl` is loaded from `raw_lvl`, and `sts_flag` and `irq` are 0. Leaving reset makes no notification.
- R2: A raw value that differs from `pub_lvl` is captured as a candidate on the first rising edge at which it is seen. It is accepted on the edge that samples the (QUAL_TICKS+1)-th tick after that capture edge, provided the raw value stays equal to the candidate throughout. `pub_lvl` takes the new value right after that edge. A tick sampled on the capture edge itself does not count.
- R3: A candidate that has seen only QUAL_TICKS ticks is not accepted. `pub_lvl` and `sts_flag` are unchanged.
- R4: If the raw value changes to another value that also differs from `pub_lvl` during qualification, the tick count restarts from zero for the newer value.
- R5: If the raw value returns to `pub_lvl` before acceptance, qualification is abandoned. A later departure starts again from zero ticks, and the return itself makes no notification.
- R6: An acceptance sets `sts_flag` to 1 after that edge. The flag then stays 1 until a cycle with `sts_clr` high clears it at the next edge.
- R7: When `sts_clr` is high on the same edge as an acceptance, the set wins and `sts_flag` stays 1.
- R8: `irq` equals `sts_flag` AND `irq_en` at all times. Turning `irq_en` off masks a pending flag without clearing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_lvl | input | LVL_W (8) | Raw guaranteed-performance level from the limit agent |
| tick | input | 1 | One-cycle qualification tick |
| irq_en | input | 1 | Interrupt enable |
| sts_clr | input | 1 | Status clear write strobe |
| pub_lvl | output | LVL_W (8) | Published, qualified level |
| sts_flag | output | 1 | Sticky change-notification flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench holds a candidate for exactly QUAL_TICKS ticks and confirms that nothing is published. It then adds one more tick and expects acceptance, so an off-by-one window would publish too early or too late.

It switches the candidate mid-window and bounces the raw level back to the published value mid-window. A design that kept counting across either event would accept before the fresh full window had elapsed.

It also lands a status clear on the accepting edge, where a clear-priority flag would drop the notification. Finally, it toggles the enable while a flag is pending, where a latched interrupt or a clearing enable would show up on `irq` or `sts_flag`.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

  // What the qualifier does on a given clock edge
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,  // keep candidate, no tick
    ACT_DROP    = 3'd1,  // raw equals published level: abandon candidate
    ACT_RESTART = 3'd2,  // new candidate value: capture and zero count
    ACT_COUNT   = 3'd3,  // tick while candidate stable, window not full
    ACT_ACCEPT  = 3'd4   // tick with full window: publish
  } qual_act_e;

  // Decision rule kept in one place so that the bench can restate it
  function automatic qual_act_e pick_act(input logic same_as_pub,
                                         input logic same_as_cand,
                                         input logic cand_vld,
                                         input logic tick,
                                         input logic win_full);
    qual_act_e a;
    if (same_as_pub)                    a = ACT_DROP;
    else if (!cand_vld || !same_as_cand) a = ACT_RESTART;
    else if (!tick)                      a = ACT_HOLD;
    else if (win_full)                   a = ACT_ACCEPT;
    else                                 a = ACT_COUNT;
    return a;
  endfunction

endpackage

// File: rtl/pcf_qualifier.sv
module pcf_qualifier
  import pcf_pkg::*;
#(
  parameter int LVL_W      = 8,
  parameter int QUAL_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] raw_lvl,
  input  logic             tick,
  output logic [LVL_W-1:0] pub_lvl,
  output logic             accept_o
);

  localparam int CNT_W = (QUAL_TICKS < 1) ? 1 : $clog2(QUAL_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(QUAL_TICKS);

  logic [LVL_W-1:0] pub_q;
  logic [LVL_W-1:0] cand_q;
  logic             cand_vld_q;
  logic [CNT_W-1:0] cnt_q;

  // Named internal events
  logic      same_as_pub;
  logic      same_as_cand;
  logic      win_full;
  qual_act_e act;

  always_comb begin
    same_as_pub  = (raw_lvl == pub_q);
    same_as_cand = (raw_lvl == cand_q);
    win_full     = (cnt_q == CNT_LIMIT);
    act          = pick_act(same_as_pub, same_as_cand, cand_vld_q, tick, win_full);
  end

  assign accept_o = (act == ACT_ACCEPT) && !rst;
  assign pub_lvl  = pub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pub_q      <= raw_lvl;
      cand_q     <= raw_lvl;
      cand_vld_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      unique case (act)
        ACT_DROP: begin
          cand_vld_q <= 1'b0;
          cnt_q      <= '0;
        end
        ACT_RESTART: begin
          cand_q     <= raw_lvl;
          cand_vld_q <= 1'b1;
          cnt_q      <= '0;
        end
        ACT_COUNT: begin
          cnt_q <= cnt_q + 1'b1;
        end
        ACT_ACCEPT: begin
          pub_q      <= cand_q;
          cand_vld_q <= 1'b0;
          cnt_q      <= '0;
        end
        default: ;
      endcase
    end
  end

  // R2: the published level moves only after an acceptance
  a_r2_pub_only_on_accept: assert property (@(posedge clk) disable iff (rst)
    !accept_o |=> $stable(pub_lvl));

  // R2: acceptance happens only on a tick
  a_r2_accept_needs_tick: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> tick);

  // R3: the tick count never runs past the window
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LIMIT);

  // R5: a raw value equal to the published level abandons qualification
  a_r5_drop_on_return: assert property (@(posedge clk) disable iff (rst)
    (raw_lvl == pub_lvl) |=> !cand_vld_q && (cnt_q == '0));

  // R4: a different raw value restarts the count
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (rst)
    (cand_vld_q && raw_lvl != cand_q && raw_lvl != pub_lvl) |=> (cnt_q == '0));

endmodule

// File: rtl/pcf_status.sv
module pcf_status (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic clr,
  input  logic ien,
  output logic sts_o,
  output logic irq_o
);

  logic sts_q;

  always_ff @(posedge clk) begin
    if (rst)         sts_q <= 1'b0;
    else if (accept) sts_q <= 1'b1;   // set wins over a same-cycle clear
    else if (clr)    sts_q <= 1'b0;
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q & ien;

  // R6: an acceptance leaves the flag set
  a_r6_set_on_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> sts_o);

  // R6: without a clear the flag is sticky
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (sts_o && !clr) |=> sts_o);

  // R7: a clear together with an acceptance does not drop the flag
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (accept && clr) |=> sts_o);

  // R6: the flag rises only after an acceptance
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(sts_o) |-> $past(accept));

endmodule

// File: rtl/perf_change_filter.sv
module perf_change_filter #(
  parameter int LVL_W      = 8,
  parameter int QUAL_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] raw_lvl,
  input  logic             tick,
  input  logic             irq_en,
  input  logic             sts_clr,
  output logic [LVL_W-1:0] pub_lvl,
  output logic             sts_flag,
  output logic             irq
);

  logic accept_ev;

  pcf_qualifier #(
    .LVL_W     (LVL_W),
    .QUAL_TICKS(QUAL_TICKS)
  ) u_qual (
    .clk     (clk),
    .rst     (rst),
    .raw_lvl (raw_lvl),
    .tick    (tick),
    .pub_lvl (pub_lvl),
    .accept_o(accept_ev)
  );

  pcf_status u_sts (
    .clk   (clk),
    .rst   (rst),
    .accept(accept_ev),
    .clr   (sts_clr),
    .ien   (irq_en),
    .sts_o (sts_flag),
    .irq_o (irq)
  );

  // R8: a rising interrupt follows an acceptance or an enable turning on
  a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(accept_ev) || ($rose(irq_en) && sts_flag)));

  // R8: the interrupt is never asserted while disabled
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);

  // R1: reset leaves no pending notification
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !sts_flag);

endmodule

// File: tb/sim_perf_change_filter.sv
module sim_perf_change_filter;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int LW         = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] raw_lvl = 8'h20;
  logic          tick = 1'b0;
  logic          irq_en = 1'b0;
  logic          sts_clr = 1'b0;
  logic [LW-1:0] pub_lvl;
  logic          sts_flag;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_change_filter #(.LVL_W(LW), .QUAL_TICKS(Q)) u0 (
    .clk(clk), .rst(rst), .raw_lvl(raw_lvl), .tick(tick),
    .irq_en(irq_en), .sts_clr(sts_clr),
    .pub_lvl(pub_lvl), .sts_flag(sts_flag), .irq(irq)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // n single-cycle ticks, one idle cycle between them; ends at a negedge
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  // Change raw and let the capture edge pass
  task automatic set_raw(input logic [LW-1:0] v);
    @(negedge clk) raw_lvl = v;
    @(negedge clk);
  endtask

  task automatic clear_sts();
    @(negedge clk) sts_clr = 1'b1;
    @(negedge clk) sts_clr = 1'b0;
  endtask

  task automatic t_reset();
    raw_lvl = 8'h33;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pub loaded", pub_lvl, 8'h33);
    chk("R1 sts", sts_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_window();
    set_raw(8'h50);
    ticks(Q);
    chk("R3 pub after Q ticks", pub_lvl, 8'h33);
    chk("R3 sts after Q ticks", sts_flag, 0);
    ticks(1);
    chk("R2 pub accepted", pub_lvl, 8'h50);
    chk("R6 sts set", sts_flag, 1);
    ticks(3);
    chk("R6 sts sticky", sts_flag, 1);
    clear_sts();
    chk("R6 sts cleared", sts_flag, 0);
  endtask

  task automatic t_restart();
    set_raw(8'h60);
    ticks(2);
    set_raw(8'h70);
    ticks(Q);
    chk("R4 no early accept", pub_lvl, 8'h50);
    chk("R4 sts still clear", sts_flag, 0);
    ticks(1);
    chk("R4 newer value accepted", pub_lvl, 8'h70);
    clear_sts();
  endtask

  task automatic t_drop();
    set_raw(8'h90);
    ticks(3);
    set_raw(8'h70);
    ticks(Q + 3);
    chk("R5 return makes no notification", sts_flag, 0);
    chk("R5 pub kept", pub_lvl, 8'h70);
    set_raw(8'h90);
    ticks(Q);
    chk("R5 count restarted", pub_lvl, 8'h70);
    ticks(1);
    chk("R5 accepted after full window", pub_lvl, 8'h90);
    clear_sts();
  endtask

  task automatic t_clear_race();
    set_raw(8'hA5);
    ticks(Q);
    @(negedge clk) begin tick = 1'b1; sts_clr = 1'b1; end
    @(negedge clk) begin tick = 1'b0; sts_clr = 1'b0; end
    chk("R7 pub accepted", pub_lvl, 8'hA5);
    chk("R7 set beats clear", sts_flag, 1);
  endtask

  task automatic t_irq();
    irq_en = 1'b0;
    #1 chk("R8 irq masked", irq, 0);
    chk("R8 flag kept while masked", sts_flag, 1);
    irq_en = 1'b1;
    #1 chk("R8 irq follows flag", irq, 1);
    clear_sts();
    chk("R8 irq drops with clear", irq, 0);
    set_raw(8'h11);
    ticks(Q + 1);
    chk("R8 irq on new accept", irq, 1);
    chk("R2 pub second accept", pub_lvl, 8'h11);
    irq_en = 1'b0;
    #1 chk("R8 irq off with enable", irq, 0);
  endtask

  initial begin
    t_reset();
    t_window();
    t_restart();
    t_drop();
    t_clear_race();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule